// File: doc/BRIEF.md
# End-Around-Carry Modular Adder

This block adds two unsigned W-bit operands (W = 32 by default) and reduces the sum modulo 2^W-1. This is the one's-complement addition used in checksum datapaths and residue arithmetic. The adder forms the (W+1)-bit raw sum and the raw sum plus one in parallel. It then picks one of them with a single select bit, so the reduction needs no magnitude comparator and no second adder in series.

A synthesis parameter chooses one of two conventions. Strict-residue mode always gives a canonical value in 0 .. 2^W-2, so a sum equal to 2^W-1 folds to zero. End-around-carry mode feeds the carry-out back as +1 only when the raw sum reaches 2^W, so the all-ones pattern (negative zero in one's complement) can appear and stays as it is. A second parameter makes the datapath either purely combinational or registered. The registered form takes a new operand pair on every clock and delivers the result one clock later.

Top module: `ones_mod_adder`

## Requirements
- R1: In strict mode (FOLD_MODE = FOLD_STRICT) the result C equals (A+B) mod (2^W-1) for every operand pair, including operands equal to all ones. C is never all ones.
- R2: In strict mode a sum of exactly 2^W-1 gives 0. Examples are 0xFFFFFFFF+0 and 0x80000000+0x7FFFFFFF.
- R3: In strict mode two all-ones operands give 0.
- R4: In end-around mode (FOLD_MODE = FOLD_EAC) C equals A+B when A+B < 2^W. Otherwise C is the low W bits of A+B+1.
- R5: In end-around mode a sum of exactly 2^W-1 gives all ones, and two all-ones operands give all ones.
- R6: In both modes a sum of exactly 2^W gives 1, and 0+0 gives 0.
- R7: With REGISTERED = 1 the block accepts a pair on every cycle in which in_valid is 1. C carries that pair's result in the next cycle, and out_valid is 1 exactly in the cycle after in_valid was 1.
- R8: With REGISTERED = 1, a cycle with in_valid at 0 leaves C unchanged in the following cycle, whatever the operands are.
- R9: With REGISTERED = 0, C is the result for the current operands in the same cycle, and out_valid equals in_valid.
- R10: While rst is 1, out_valid is 0. With REGISTERED = 1, C is 0 in the cycle after a reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair on op_a/op_b is valid |
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| out_valid | output | 1 | Result on sum_c is valid |
| sum_c | output | WIDTH | Reduced sum |

## Verification
In the registered form, taking a new pair and presenting the previous pair's result happen in the same cycle. The bench drives back-to-back valid pairs that mix boundary sums (2^W-1, 2^W, all-ones operands) with idle cycles full of random operand values. A scoreboard queue holds one expected item per cycle, and each registered output is compared one edge later against a 64-bit reference. Both fold conventions run side by side on the same stimulus, in combinational and registered form.

// File: rtl/modadd_pkg.sv
package modadd_pkg;

    // Reduction convention applied to the (W+1)-bit raw sum
    typedef enum logic [0:0] {
        FOLD_STRICT = 1'b0,  // canonical residue: 2^W-1 folds to zero
        FOLD_EAC    = 1'b1   // end-around carry: all-ones left as is
    } fold_mode_e;

    localparam int DATA_W_DEFAULT = 32;

    // Select source for the final result
    typedef enum logic [1:0] {
        PICK_RAW  = 2'd0,
        PICK_INC  = 2'd1,
        PICK_ZERO = 2'd2
    } pick_e;

endpackage

// File: rtl/modadd_sumgen.sv
module modadd_sumgen #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W:0]   raw,
    output logic [W:0]   inc
);
    localparam int SW = W + 1;

    // Two adders side by side: the raw sum and the sum with carry-in set
    always_comb begin
        raw = SW'(a) + SW'(b);
        inc = SW'(a) + SW'(b) + SW'(1);
    end
endmodule

// File: rtl/modadd_fold.sv
module modadd_fold
    import modadd_pkg::*;
#(
    parameter int         W    = 32,
    parameter fold_mode_e MODE = FOLD_STRICT
) (
    input  logic [W:0]   raw,
    input  logic [W:0]   inc,
    output logic [W-1:0] res
);
    pick_e pick;

    generate
        if (MODE == FOLD_STRICT) begin : g_strict
            // Carry out of sum+1 means sum >= 2^W-1. The only case where
            // sum+1 truncates to all ones is both operands all ones.
            logic wrap_ones;
            assign wrap_ones = inc[W] & (&inc[W-1:0]);
            always_comb begin
                if (wrap_ones)   pick = PICK_ZERO;
                else if (inc[W]) pick = PICK_INC;
                else             pick = PICK_RAW;
            end
        end else begin : g_eac
            // Carry out of the raw sum selects the +1 path
            logic inc_top_unused;
            assign inc_top_unused = inc[W];
            always_comb begin
                pick = raw[W] ? PICK_INC : PICK_RAW;
            end
        end
    endgenerate

    always_comb begin
        unique case (pick)
            PICK_INC:  res = inc[W-1:0];
            PICK_ZERO: res = '0;
            default:   res = raw[W-1:0];
        endcase
    end
endmodule

// File: rtl/modadd_stage.sv
module modadd_stage #(
    parameter int W   = 32,
    parameter bit REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         vld_in,
    input  logic [W-1:0] res_in,
    output logic         vld_out,
    output logic [W-1:0] res_out
);
    generate
        if (REG) begin : g_reg
            logic         vld_q;
            logic [W-1:0] res_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_q <= 1'b0;
                    res_q <= '0;
                end else begin
                    vld_q <= vld_in;
                    if (vld_in) res_q <= res_in;
                end
            end
            assign vld_out = vld_q;
            assign res_out = res_q;
        end else begin : g_comb
            logic clk_unused;
            assign clk_unused = clk;
            assign vld_out = vld_in & ~rst;
            assign res_out = res_in;
        end
    endgenerate
endmodule

// File: rtl/ones_mod_adder.sv
module ones_mod_adder
    import modadd_pkg::*;
#(
    parameter int         WIDTH      = DATA_W_DEFAULT,
    parameter fold_mode_e FOLD_MODE  = FOLD_STRICT,
    parameter bit         REGISTERED = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic             out_valid,
    output logic [WIDTH-1:0] sum_c
);
    logic [WIDTH:0]   raw_sum;
    logic [WIDTH:0]   inc_sum;
    logic [WIDTH-1:0] folded;

    modadd_sumgen #(.W(WIDTH)) u_sum (
        .a   (op_a),
        .b   (op_b),
        .raw (raw_sum),
        .inc (inc_sum)
    );

    modadd_fold #(.W(WIDTH), .MODE(FOLD_MODE)) u_fold (
        .raw (raw_sum),
        .inc (inc_sum),
        .res (folded)
    );

    modadd_stage #(.W(WIDTH), .REG(REGISTERED)) u_stage (
        .clk     (clk),
        .rst     (rst),
        .vld_in  (in_valid),
        .res_in  (folded),
        .vld_out (out_valid),
        .res_out (sum_c)
    );
endmodule

// File: rtl/modadd_chk.sv
module modadd_chk #(
    parameter int W      = 32,
    parameter bit STRICT = 1'b1,
    parameter bit REG    = 1'b1
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         out_valid,
    input logic [W-1:0] sum_c
);
    localparam logic [W:0] MODV = {1'b0, {W{1'b1}}};
    localparam logic [W:0] TWOW = {1'b1, {W{1'b0}}};

    logic [W:0]   s_wide;
    logic [W-1:0] ref_val;
    logic [W:0]   tmp;

    always_comb begin
        s_wide = {1'b0, op_a} + {1'b0, op_b};
        if (STRICT) tmp = s_wide % MODV;
        else        tmp = (s_wide >= TWOW) ? (s_wide - MODV) : s_wide;
        ref_val = tmp[W-1:0];
    end

    generate
        if (REG) begin : g_reg
            assert_valid_lat_R7: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid);
            assert_valid_idle_R7: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> !out_valid);
            assert_value_R1_R4: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> (sum_c == $past(ref_val)));
            assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> $stable(sum_c));
            assert_reset_R10: assert property (@(posedge clk)
                rst |=> (!out_valid && sum_c == '0));
        end else begin : g_comb
            assert_same_cycle_R9: assert property (@(posedge clk) disable iff (rst)
                out_valid == in_valid);
            assert_value_R9: assert property (@(posedge clk) disable iff (rst)
                in_valid |-> (sum_c == ref_val));
            assert_reset_R10: assert property (@(posedge clk)
                rst |-> !out_valid);
        end
        if (STRICT) begin : g_canon
            assert_canonical_R1: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> (sum_c != {W{1'b1}}));
        end
    endgenerate
endmodule

bind ones_mod_adder modadd_chk #(
    .W      (WIDTH),
    .STRICT (FOLD_MODE == modadd_pkg::FOLD_STRICT),
    .REG    (REGISTERED)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .sum_c     (sum_c)
);

// File: tb/sim_ones_mod_adder.sv
module sim_ones_mod_adder;
    import modadd_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;

    logic        v0, v1, v2, v3;
    logic [31:0] c0, c1, c2, c3;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    // u0: strict registered, u1: end-around registered,
    // u2: strict combinational, u3: end-around combinational
    ones_mod_adder #(.FOLD_MODE(FOLD_STRICT), .REGISTERED(1'b1)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(v0), .sum_c(c0));
    ones_mod_adder #(.FOLD_MODE(FOLD_EAC), .REGISTERED(1'b1)) u1 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(v1), .sum_c(c1));
    ones_mod_adder #(.FOLD_MODE(FOLD_STRICT), .REGISTERED(1'b0)) u2 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(v2), .sum_c(c2));
    ones_mod_adder #(.FOLD_MODE(FOLD_EAC), .REGISTERED(1'b0)) u3 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(v3), .sum_c(c3));

    typedef struct {
        logic        vld;
        logic [31:0] strict_v;
        logic [31:0] eac_v;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] last_s = '0;
    logic [31:0] last_e = '0;

    function automatic logic [31:0] ref_strict(logic [31:0] a, logic [31:0] b);
        logic [63:0] s;
        logic [63:0] r;
        s = {32'd0, a} + {32'd0, b};
        r = s % 64'h0000_0000_FFFF_FFFF;
        return r[31:0];
    endfunction

    function automatic logic [31:0] ref_eac(logic [31:0] a, logic [31:0] b);
        logic [63:0] s;
        logic [63:0] r;
        s = {32'd0, a} + {32'd0, b};
        r = (s >= 64'h1_0000_0000) ? (s - 64'h0000_0000_FFFF_FFFF) : s;
        return r[31:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: one call per cycle, combinational outputs checked in place,
    // registered expectations queued for the monitor
    task automatic drive(input logic vld, input logic [31:0] a, input logic [31:0] b,
                         input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = vld;
        op_a     = a;
        op_b     = b;
        #1;
        check({"R9 valid ", tag}, {31'd0, v2}, {31'd0, vld});
        check({"R9 valid ", tag}, {31'd0, v3}, {31'd0, vld});
        check({"R1 R9 comb strict ", tag}, c2, ref_strict(a, b));
        check({"R4 R9 comb eac ", tag}, c3, ref_eac(a, b));
        if (vld) begin
            last_s = ref_strict(a, b);
            last_e = ref_eac(a, b);
        end
        e.vld      = vld;
        e.strict_v = last_s;
        e.eac_v    = last_e;
        e.tag      = tag;
        sb.push_back(e);
    endtask

    // Monitor: compares registered outputs just after the capturing edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check({"R7 valid ", e.tag}, {31'd0, v0}, {31'd0, e.vld});
                check({"R7 valid ", e.tag}, {31'd0, v1}, {31'd0, e.vld});
                check({(e.vld ? "R7 strict " : "R8 hold strict "), e.tag}, c0, e.strict_v);
                check({(e.vld ? "R7 eac " : "R8 hold eac "), e.tag}, c1, e.eac_v);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R10: reset state with a valid pair presented
        in_valid = 1'b1;
        op_a = 32'h1234_5678;
        op_b = 32'h1111_1111;
        repeat (3) @(negedge clk);
        check("R10 reg valid", {31'd0, v0}, 32'd0);
        check("R10 reg result", c0, 32'd0);
        check("R10 reg eac result", c1, 32'd0);
        check("R10 comb valid", {31'd0, v2}, 32'd0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(posedge clk);
        #2;
        check("R10 reg idle after reset", c0, 32'd0);

        // Directed boundary pairs, back to back
        drive(1'b1, 32'h0000_0000, 32'h0000_0000, "R6 zero");
        drive(1'b1, 32'hFFFF_FFFF, 32'h0000_0000, "R2 R5 ones+0");
        drive(1'b1, 32'h8000_0000, 32'h7FFF_FFFF, "R2 R5 sum 2^W-1");
        drive(1'b1, 32'h8000_0000, 32'h8000_0000, "R6 sum 2^W");
        drive(1'b1, 32'hFFFF_FFFF, 32'h0000_0001, "R6 ones+1");
        drive(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 R5 max");
        drive(1'b0, 32'hDEAD_BEEF, 32'h0BAD_F00D, "R8 idle");
        drive(1'b0, 32'hFFFF_FFFF, 32'h0000_0000, "R8 idle2");
        drive(1'b1, 32'hFFFF_FFFE, 32'h0000_0001, "R2 R5 near");
        drive(1'b1, 32'h0000_0005, 32'h0000_0007, "R1 R4 small");

        // Direct spot checks of the named boundary values
        drive(1'b1, 32'hFFFF_FFFF, 32'h0000_0000, "R2 spot");
        check("R2 strict ones+0 is zero", c2, 32'h0000_0000);
        check("R5 eac ones+0 stays ones", c3, 32'hFFFF_FFFF);
        drive(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 spot");
        check("R3 strict max is zero", c2, 32'h0000_0000);
        check("R5 eac max is ones", c3, 32'hFFFF_FFFF);
        drive(1'b1, 32'hC000_0000, 32'h4000_0000, "R6 spot");
        check("R6 strict 2^W is one", c2, 32'h0000_0001);
        check("R6 eac 2^W is one", c3, 32'h0000_0001);

        // Random pairs with random gaps
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra;
            logic [31:0] rb;
            logic        rv;
            ra = $urandom;
            rb = $urandom;
            rv = ($urandom % 4) != 0;
            if (i % 17 == 0) rb = 32'hFFFF_FFFF - ra;
            drive(rv, ra, rb, "R1 R4 random");
        end
        drive(1'b0, 32'd0, 32'd0, "R8 drain");
        @(posedge clk);
        #3;

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule